// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt and Ready Flag Generator

This block sits next to the transmit and receive FIFOs of a UART channel. It turns their fill counts into a transmit-ready request, a receive-ready request and a combined interrupt. It has two request modes, chosen by one bit of the FIFO control byte. In per-character mode, the receive side requests service as soon as one character is waiting, and the transmit side requests service once its queue has drained to zero. In block mode, each side compares its count against its own programmable threshold. This lets a DMA engine or an interrupt handler move a whole burst of characters at a time.

The block also keeps the FIFO control byte. It splits that byte into an enable, a mode bit, two 2-bit threshold codes and two self-clearing flush strobes. The flush strobes go to the FIFOs, which clear their own counts. From the transmit count and the shifter's busy signal, the block also produces the two transmitter flags of the line status register: room in the holding path, and transmitter fully idle.

Top module: `fifo_trig_irq`

## Requirements
- R1: While reset is held, every output is 0, and the stored control byte reads as zero: FIFOs disabled, per-character mode, both threshold codes 0.
- R2: A write (`fcr_we`=1) stores the control byte on that clock edge. Bit 0 is the FIFO enable, bit 3 selects block mode (1) or per-character mode (0), and bits 7:6 are the receive threshold code.
- R3: In the cycle after a write, `rx_flush` equals written bit 1 and `tx_flush` equals written bit 2. Each strobe drops again one cycle later unless a new write sets it.
- R4: When block mode is not in effect (FIFO enable 0 or mode bit 0), `rx_rdy` is 1 exactly when the receive count is non-zero, and `tx_rdy` is 1 exactly when the transmit count is zero.
- R5: In block mode (enable 1 and mode 1), `tx_rdy` is 1 exactly when the transmit count is strictly below the transmit threshold. Codes 0, 1, 2 and 3 select thresholds of 8, 16, 32 and 56.
- R6: In block mode, `rx_rdy` is 1 exactly when the receive count is strictly above the receive threshold. Codes 0, 1, 2 and 3 select thresholds of 8, 16, 56 and 60.
- R7: The transmit threshold code (bits 5:4) is stored from a write only when `enh_en` is 1. A write made with `enh_en`=0 sets the code to 0, which selects a threshold of 8.
- R8: `irq` is the OR of the transmit and receive requests computed in the same cycle.
- R9: `thr_room` is 1 when the transmit count is below the depth (64) with FIFOs enabled, or when the count is zero with FIFOs disabled.
- R10: `tx_idle` is 1 exactly when the transmit count is zero and `tx_shift_busy` is 0.
- R11: Every request and flag output is registered. It reflects the counts, the busy input and the stored control of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_we | input | 1 | Write strobe for the FIFO control byte |
| fcr_wdata | input | 8 | FIFO control byte value |
| enh_en | input | 1 | Enhanced-feature enable; gates the transmit threshold field |
| tx_count | input | 7 | Characters in the transmit FIFO (0..64) |
| rx_count | input | 7 | Characters in the receive FIFO (0..64) |
| tx_shift_busy | input | 1 | Transmit shift register is sending a character |
| irq | output | 1 | Interrupt request |
| tx_rdy | output | 1 | Transmit side requests more data |
| rx_rdy | output | 1 | Receive side requests unloading |
| thr_room | output | 1 | Holding path has at least one free location |
| tx_idle | output | 1 | Transmit FIFO and shifter both empty |
| rx_flush | output | 1 | One-cycle receive FIFO clear strobe |
| tx_flush | output | 1 | One-cycle transmit FIFO clear strobe |

## Verification
Every request and flag output is due one clock edge after the counts or the busy input change. A control write affects those outputs only on the edge after the one that stored it. Each flush strobe is high only during the single cycle that follows its write edge. The bench changes inputs on falling edges and allows exactly one rising edge before it samples, on the next falling edge. It therefore reads each result in its own cycle and never one cycle early or late. Flush strobes are checked high right after the write, and then low after one more edge.

// File: rtl/fti_pkg.sv
package fti_pkg;

   // Stored FIFO control fields
   typedef struct packed {
      logic       fifo_en;
      logic       blk_mode;
      logic [1:0] rx_code;
      logic [1:0] tx_code;
   } fti_cfg_t;

   // Bit positions inside the control byte
   localparam int B_EN      = 0;
   localparam int B_RXFLUSH = 1;
   localparam int B_TXFLUSH = 2;
   localparam int B_MODE    = 3;
   localparam int B_TXLO    = 4;
   localparam int B_RXLO    = 6;

endpackage

// File: rtl/fti_fcr_reg.sv
module fti_fcr_reg
   import fti_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   input  logic       enh_en,
   output fti_cfg_t   cfg,
   output logic       rx_flush,
   output logic       tx_flush
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '0;
         rx_flush <= 1'b0;
         tx_flush <= 1'b0;
      end else begin
         rx_flush <= we & wdata[B_RXFLUSH];
         tx_flush <= we & wdata[B_TXFLUSH];
         if (we) begin
            cfg.fifo_en  <= wdata[B_EN];
            cfg.blk_mode <= wdata[B_MODE];
            cfg.rx_code  <= wdata[B_RXLO +: 2];
            cfg.tx_code  <= enh_en ? wdata[B_TXLO +: 2] : 2'd0;
         end
      end
   end

   // R3: a strobe only follows a write that requested it
   p_rx_flush_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |-> $past(we && wdata[B_RXFLUSH]));
   p_tx_flush_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |-> $past(we && wdata[B_TXFLUSH]));

endmodule

// File: rtl/fti_trig.sv
module fti_trig #(
   parameter int CNT_W = 7,
   parameter bit ABOVE = 1'b0
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] lvl,
   input  logic             blk,
   output logic             req
);

   generate
      if (ABOVE) begin : g_above
         // receive side: fill beyond threshold, or any character waiting
         always_comb req = blk ? (cnt > lvl) : (cnt != '0);
      end else begin : g_below
         // transmit side: drained below threshold, or fully drained
         always_comb req = blk ? (cnt < lvl) : (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/fti_lsr_flags.sv
module fti_lsr_flags #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7
) (
   input  logic [CNT_W-1:0] tx_cnt,
   input  logic             fifo_en,
   input  logic             busy,
   output logic             room,
   output logic             idle
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   always_comb begin
      room = fifo_en ? (tx_cnt < FULL) : (tx_cnt == '0);
      idle = (tx_cnt == '0) && !busy;
   end

endmodule

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq #(
   parameter int DEPTH  = 64,
   parameter int RX_L0  = 8,
   parameter int RX_L1  = 16,
   parameter int RX_L2  = 56,
   parameter int RX_L3  = 60,
   parameter int TX_L0  = 8,
   parameter int TX_L1  = 16,
   parameter int TX_L2  = 32,
   parameter int TX_L3  = 56,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fcr_we,
   input  logic [7:0]       fcr_wdata,
   input  logic             enh_en,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             tx_shift_busy,
   output logic             irq,
   output logic             tx_rdy,
   output logic             rx_rdy,
   output logic             thr_room,
   output logic             tx_idle,
   output logic             rx_flush,
   output logic             tx_flush
);
   import fti_pkg::*;

   // elaboration-time parameter checks
   if (DEPTH < 4) begin : g_bad_depth
      $error("fifo_trig_irq: DEPTH must be at least 4");
   end
   if (RX_L0 < 1 || RX_L3 >= DEPTH || RX_L0 > RX_L1 || RX_L1 > RX_L2 || RX_L2 > RX_L3) begin : g_bad_rx
      $error("fifo_trig_irq: receive thresholds must rise and stay below DEPTH");
   end
   if (TX_L0 < 1 || TX_L3 >= DEPTH || TX_L0 > TX_L1 || TX_L1 > TX_L2 || TX_L2 > TX_L3) begin : g_bad_tx
      $error("fifo_trig_irq: transmit thresholds must rise and stay below DEPTH");
   end

   fti_cfg_t         cfg;
   logic             blk;
   logic [CNT_W-1:0] rx_lvl, tx_lvl;
   logic             rx_req, tx_req, room_d, idle_d;

   fti_fcr_reg u_fcr (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (fcr_we),
      .wdata    (fcr_wdata),
      .enh_en   (enh_en),
      .cfg      (cfg),
      .rx_flush (rx_flush),
      .tx_flush (tx_flush)
   );

   assign blk = cfg.fifo_en & cfg.blk_mode;

   always_comb begin
      case (cfg.rx_code)
         2'd0:    rx_lvl = CNT_W'(RX_L0);
         2'd1:    rx_lvl = CNT_W'(RX_L1);
         2'd2:    rx_lvl = CNT_W'(RX_L2);
         default: rx_lvl = CNT_W'(RX_L3);
      endcase
      case (cfg.tx_code)
         2'd0:    tx_lvl = CNT_W'(TX_L0);
         2'd1:    tx_lvl = CNT_W'(TX_L1);
         2'd2:    tx_lvl = CNT_W'(TX_L2);
         default: tx_lvl = CNT_W'(TX_L3);
      endcase
   end

   fti_trig #(.CNT_W(CNT_W), .ABOVE(1'b1)) u_rx_trig (
      .cnt (rx_count),
      .lvl (rx_lvl),
      .blk (blk),
      .req (rx_req)
   );

   fti_trig #(.CNT_W(CNT_W), .ABOVE(1'b0)) u_tx_trig (
      .cnt (tx_count),
      .lvl (tx_lvl),
      .blk (blk),
      .req (tx_req)
   );

   fti_lsr_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lsr (
      .tx_cnt  (tx_count),
      .fifo_en (cfg.fifo_en),
      .busy    (tx_shift_busy),
      .room    (room_d),
      .idle    (idle_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         tx_rdy   <= 1'b0;
         rx_rdy   <= 1'b0;
         thr_room <= 1'b0;
         tx_idle  <= 1'b0;
      end else begin
         irq      <= tx_req | rx_req;
         tx_rdy   <= tx_req;
         rx_rdy   <= rx_req;
         thr_room <= room_d;
         tx_idle  <= idle_d;
      end
   end

   // one cycle after reset release, $past values are meaningful
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_irq_is_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (tx_rdy || rx_rdy));
   p_idle_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_idle |-> thr_room);
   p_idle_needs_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_idle |-> ($past(tx_count) == '0 && !$past(tx_shift_busy)));
   p_char_mode_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(blk)) |-> (rx_rdy == ($past(rx_count) != '0)));
   p_char_mode_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(blk)) |-> (tx_rdy == ($past(tx_count) == '0)));

endmodule

// File: tb/test_fifo_trig_irq.sv
module test_fifo_trig_irq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fcr_we = 1'b0;
   logic [7:0] fcr_wdata = '0;
   logic       enh_en = 1'b0;
   logic [6:0] tx_count = '0;
   logic [6:0] rx_count = '0;
   logic       tx_shift_busy = 1'b0;
   logic       irq, tx_rdy, rx_rdy, thr_room, tx_idle, rx_flush, tx_flush;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model of stored control
   bit m_en, m_blk;
   int m_rxc, m_txc;

   always #5 clk = ~clk;

   fifo_trig_irq i_fifo_trig_irq (
      .clk, .rst_n, .fcr_we, .fcr_wdata, .enh_en, .tx_count, .rx_count,
      .tx_shift_busy, .irq, .tx_rdy, .rx_rdy, .thr_room, .tx_idle,
      .rx_flush, .tx_flush
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int rx_level(int c);
      return (c < 2) ? (8 << c) : (56 + 4 * (c - 2));
   endfunction

   function automatic int tx_level(int c);
      return (c < 3) ? (8 << c) : 56;
   endfunction

   // at a falling edge: write the control byte, then check the strobes
   task automatic wr_fcr(bit en, bit rxf, bit txf, bit blk, int txc, int rxc, bit enh);
      fcr_wdata = {2'(rxc), 2'(txc), blk, txf, rxf, en};
      enh_en = enh;
      fcr_we = 1'b1;
      @(negedge clk);
      fcr_we = 1'b0;
      m_en = en; m_blk = blk; m_rxc = rxc;
      m_txc = enh ? txc : 0;
      chk("R3", "rx_flush after write", int'(rx_flush), int'(rxf));
      chk("R3", "tx_flush after write", int'(tx_flush), int'(txf));
   endtask

   // at a falling edge: drive counts, allow one rising edge, check
   task automatic apply(int rc, int tc, bit busy, string req);
      bit b, erx, etx;
      rx_count = 7'(rc);
      tx_count = 7'(tc);
      tx_shift_busy = busy;
      @(negedge clk);
      b   = m_en && m_blk;
      erx = b ? (rc > rx_level(m_rxc)) : (rc != 0);
      etx = b ? (tc < tx_level(m_txc)) : (tc == 0);
      chk(req, "rx_rdy", int'(rx_rdy), int'(erx));
      chk(req, "tx_rdy", int'(tx_rdy), int'(etx));
      chk("R8", "irq", int'(irq), int'(erx | etx));
      chk("R9", "thr_room", int'(thr_room), int'(m_en ? (tc < 64) : (tc == 0)));
      chk("R10", "tx_idle", int'(tx_idle), int'(tc == 0 && !busy));
      chk("R3", "rx_flush cleared", int'(rx_flush), 0);
      chk("R3", "tx_flush cleared", int'(tx_flush), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rx_count = 7'd5;
      tx_count = 7'd0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "irq in reset", int'(irq), 0);
      chk("R1", "tx_rdy in reset", int'(tx_rdy), 0);
      chk("R1", "rx_rdy in reset", int'(rx_rdy), 0);
      chk("R1", "thr_room in reset", int'(thr_room), 0);
      chk("R1", "tx_idle in reset", int'(tx_idle), 0);
      chk("R1", "flush in reset", int'(rx_flush | tx_flush), 0);
      rst_n = 1'b1;
      m_en = 0; m_blk = 0; m_rxc = 0; m_txc = 0;
      // R1/R4: stored control is zero -> per-character behaviour
      apply(5, 0, 1'b0, "R1");
      apply(0, 3, 1'b1, "R4");

      // R2 R4 R5 R6 R11: full sweep over enable, mode and both codes
      for (int cf = 0; cf < 32; cf++) begin
         wr_fcr(cf[0], cf[1], cf[2], cf[1], cf[4:3], cf[4:3] ^ 2'(cf[0]), 1'b1);
         for (int c = 0; c <= 64; c++) begin
            apply(c, 64 - c, (c % 3) == 0, (cf[0] && cf[1]) ? "R5/R6" : "R4");
         end
      end

      // R7: transmit code ignored without enhanced enable
      wr_fcr(1'b1, 1'b0, 1'b0, 1'b1, 3, 2, 1'b1);
      apply(0, 20, 1'b0, "R7");   // code 3 -> threshold 56 -> request
      chk("R7", "tx_rdy code3", int'(tx_rdy), 1);
      wr_fcr(1'b1, 1'b0, 1'b0, 1'b1, 3, 2, 1'b0);
      apply(0, 20, 1'b0, "R7");   // code forced to 0 -> threshold 8
      chk("R7", "tx_rdy forced code0", int'(tx_rdy), 0);
      apply(0, 7, 1'b0, "R7");
      chk("R7", "tx_rdy below 8", int'(tx_rdy), 1);

      // R6 boundary: receive threshold 60 needs 61
      wr_fcr(1'b1, 1'b1, 1'b1, 1'b1, 0, 3, 1'b1);
      apply(60, 40, 1'b0, "R6");
      apply(61, 40, 1'b0, "R6");
      // R11: one-edge latency of a count change
      rx_count = 7'd0;
      tx_count = 7'd0;
      #1;
      chk("R11", "rx_rdy holds before edge", int'(rx_rdy), 1);
      @(negedge clk);
      chk("R11", "rx_rdy after edge", int'(rx_rdy), 0);
      chk("R11", "tx_idle after edge", int'(tx_idle), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule